// File: doc/BRIEF.md
# Audio Oversampled Clock Generator

This block turns one fast serial-interface clock into the three clocks an audio port and its codec need: a master clock for the codec, a bit clock, and a left/right frame clock. The incoming clock runs at either 512 or 384 times the sample rate. A small set of plain configuration pins picks that base, a 3-bit power-of-two divide code for the master clock, and whether a frame holds 32 or 48 bit clocks (the wider frame carries 20- and 24-bit samples).

A run pin starts the generator and a gate pin stops every output at once. The configuration is captured only while run is low, so software can stage the next setting during playback and it applies at the next start. The bit and frame clocks also leave the block on a second pair of pins, so a slaved port instance can run from the same clock set and the same sample rate. There is no data stream through this block; every pin is a plain level.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, mclk_o, bclk_o, fclk_o, both peer outputs and cfg_err_o are all low.
- R2: With cfg_base384_i = 0 (input at 512 fs) and cfg_mult_i = k for k from 0 to 4, mclk_o has a period of 2^k input clocks and a 50% duty cycle, giving 512, 256, 128, 64 and 32 fs.
- R3: With cfg_base384_i = 1 (input at 384 fs) and cfg_mult_i = k for k from 0 to 3, mclk_o has a period of 2^k input clocks and a 50% duty cycle, giving 384, 192, 96 and 48 fs.
- R4: bclk_o has a 50% duty cycle and a period of 16 input clocks for base 512 with cfg_wide48_i = 0, 12 input clocks for base 384 with cfg_wide48_i = 0, and 8 input clocks for base 384 with cfg_wide48_i = 1 (32 fs or 48 fs).
- R5: fclk_o has a 50% duty cycle and stays at each level for 16 bit clocks when cfg_wide48_i = 0 and 24 bit clocks when it is 1.
- R6: fclk_o changes only in the input-clock cycle in which bclk_o falls.
- R7: All clock outputs are low while run_i is 0 or gate_i is 1, reaching that state within two input clocks; they resume when run_i is 1 and gate_i is 0.
- R8: Changes on cfg_base384_i, cfg_mult_i and cfg_wide48_i while run_i is 1 have no effect on the outputs; the setting present when run_i was last low applies after the next start.
- R9: cfg_err_o is 1 and all clock outputs stay low when the captured setting is base 512 with cfg_wide48_i = 1, base 512 with a code above 4, or base 384 with a code above 3.
- R10: peer_bclk_o and peer_fclk_o always equal bclk_o and fclk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial-interface clock, 512 or 384 fs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base384_i | input | 1 | 0: input is 512 fs, 1: input is 384 fs |
| cfg_mult_i | input | 3 | Master-clock divide code, divide by 2^code |
| cfg_wide48_i | input | 1 | 1: 48 bit clocks per frame, 0: 32 |
| run_i | input | 1 | Starts the generator; configuration captured while low |
| gate_i | input | 1 | Forces every clock output low |
| mclk_o | output | 1 | Codec master clock |
| bclk_o | output | 1 | Bit clock of this port |
| fclk_o | output | 1 | Frame (left/right) clock of this port |
| peer_bclk_o | output | 1 | Bit clock for the slaved port instance |
| peer_fclk_o | output | 1 | Frame clock for the slaved port instance |
| cfg_err_o | output | 1 | Captured setting is an illegal combination |

## Verification
The divided clocks come from registers one input clock after run is sampled high, the undivided master clock follows the input clock from the next falling edge, and cfg_err_o settles two input clocks after a setting is captured. The bench waits at least three input clocks after each control change before observing, and it samples both the high and low phase of every input cycle, one nanosecond after each edge. Periods and duty cycles are measured as distances between consecutive rising edges in those half-cycle samples, so start-up latency cannot bias a result; quiet checks look for any high sample over a window.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
  localparam int MULT_W      = 3;
  localparam int CODE_MAX512 = 4;
  localparam int CODE_MAX384 = 3;
  localparam int HALF_W      = 3;
  localparam int FHALF_W     = 5;

  typedef struct packed {
    logic              base384;
    logic [MULT_W-1:0] mult;
    logic              wide48;
  } acg_cfg_t;

  function automatic logic cfg_legal(input acg_cfg_t c);
    if (!c.base384 && c.wide48) return 1'b0;
    if (c.base384) return (c.mult <= MULT_W'(CODE_MAX384));
    return (c.mult <= MULT_W'(CODE_MAX512));
  endfunction

  // input clocks per bit-clock half period, minus one
  function automatic logic [HALF_W-1:0] bit_half_m1(input acg_cfg_t c);
    if (!c.base384) return HALF_W'(7);
    if (c.wide48)   return HALF_W'(3);
    return HALF_W'(5);
  endfunction

  // bit clocks per frame-clock level, minus one
  function automatic logic [FHALF_W-1:0] frame_half_m1(input acg_cfg_t c);
    return c.wide48 ? FHALF_W'(23) : FHALF_W'(15);
  endfunction
endpackage

// File: rtl/acg_cfg_hold.sv
`timescale 1ns/1ps
module acg_cfg_hold
  import acg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  acg_cfg_t cfg_i,
  output acg_cfg_t cfg_q_o,
  output logic     legal_o,
  output logic     err_o
);
  acg_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_o <= 1'b0;
    end else begin
      if (!run_i) cfg_q <= cfg_i;
      err_o <= ~cfg_legal(cfg_q);
    end
  end

  assign cfg_q_o = cfg_q;
  assign legal_o = cfg_legal(cfg_q);

  // R8: captured setting frozen while running
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(cfg_q));
endmodule

// File: rtl/acg_mclk_div.sv
`timescale 1ns/1ps
module acg_mclk_div #(
  parameter int CODE_W = 3,
  parameter int NDIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              mclk_o
);
  logic [NDIV-1:0] cnt;
  logic            en_n;
  logic            sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt <= '0;
    else if (!en_i) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // enable retimed on the falling edge so the undivided path gates cleanly
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_n <= 1'b0;
    else         en_n <= en_i;
  end

  always_comb begin
    sel = 1'b0;
    if (code_i == '0) sel = clk_i & en_n;
    for (int k = 1; k <= NDIV; k++)
      if (code_i == CODE_W'(k)) sel = cnt[k-1];
  end

  assign mclk_o = sel;

  // R7: divider returns to zero once stopped
  a_r7_div_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt == '0));
endmodule

// File: rtl/acg_bclk_gen.sv
`timescale 1ns/1ps
module acg_bclk_gen #(
  parameter int HALF_W  = 3,
  parameter int FHALF_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [HALF_W-1:0]  half_m1_i,
  input  logic [FHALF_W-1:0] fhalf_m1_i,
  output logic               bclk_o,
  output logic               fclk_o
);
  logic [HALF_W-1:0]  hcnt;
  logic [FHALF_W-1:0] fcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt <= '0; fcnt <= '0; bclk_o <= 1'b0; fclk_o <= 1'b0;
    end else if (!en_i) begin
      hcnt <= '0; fcnt <= '0; bclk_o <= 1'b0; fclk_o <= 1'b0;
    end else if (hcnt == half_m1_i) begin
      hcnt   <= '0;
      bclk_o <= ~bclk_o;
      if (bclk_o) begin
        if (fcnt == fhalf_m1_i) begin
          fcnt   <= '0;
          fclk_o <= ~fclk_o;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R7: stopped generator holds its clocks low
  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bclk_o && !fclk_o));
  // R6: frame clock moves only with a falling bit clock
  a_r6_frame_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$stable(fclk_o)) |-> $fell(bclk_o));
endmodule

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen
  import acg_pkg::*;
#(
  parameter int NDIV = CODE_MAX512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_base384_i,
  input  logic [MULT_W-1:0] cfg_mult_i,
  input  logic              cfg_wide48_i,
  input  logic              run_i,
  input  logic              gate_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              peer_bclk_o,
  output logic              peer_fclk_o,
  output logic              cfg_err_o
);
  acg_cfg_t cfg_in, cfg_q;
  logic     legal;
  logic     run_q;
  logic     bclk, fclk;

  assign cfg_in = '{base384: cfg_base384_i, mult: cfg_mult_i, wide48: cfg_wide48_i};

  acg_cfg_hold u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .cfg_i   (cfg_in),
    .cfg_q_o (cfg_q),
    .legal_o (legal),
    .err_o   (cfg_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= run_i & ~gate_i & legal;
  end

  acg_mclk_div #(.CODE_W(MULT_W), .NDIV(NDIV)) u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_q),
    .code_i (cfg_q.mult),
    .mclk_o (mclk_o)
  );

  acg_bclk_gen #(.HALF_W(HALF_W), .FHALF_W(FHALF_W)) u_bclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (run_q),
    .half_m1_i  (bit_half_m1(cfg_q)),
    .fhalf_m1_i (frame_half_m1(cfg_q)),
    .bclk_o     (bclk),
    .fclk_o     (fclk)
  );

  assign bclk_o      = bclk;
  assign fclk_o      = fclk;
  assign peer_bclk_o = bclk;
  assign peer_fclk_o = fclk;

  // R9: an illegal captured setting never lets the generator run
  a_r9_illegal_stays_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !run_q);
endmodule

// File: tb/sim_audio_clkgen.sv
`timescale 1ns/1ps
module sim_audio_clkgen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, base, wide, run, gate;
  logic [2:0] mult;
  logic mclk, bclk, fclk, pbclk, pfclk, err;

  audio_clkgen u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base384_i(base), .cfg_mult_i(mult),
    .cfg_wide48_i(wide), .run_i(run), .gate_i(gate), .mclk_o(mclk),
    .bclk_o(bclk), .fclk_o(fclk), .peer_bclk_o(pbclk), .peer_fclk_o(pfclk),
    .cfg_err_o(err)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // {base, mult, wide, mclk period, bclk period, fclk period} in half-cycle samples
  localparam logic [28:0] VEC [9] = '{
    {1'b0, 3'd0, 1'b0, 7'd2,  6'd32, 11'd1024},
    {1'b0, 3'd1, 1'b0, 7'd4,  6'd32, 11'd1024},
    {1'b0, 3'd2, 1'b0, 7'd8,  6'd32, 11'd1024},
    {1'b0, 3'd3, 1'b0, 7'd16, 6'd32, 11'd1024},
    {1'b0, 3'd4, 1'b0, 7'd32, 6'd32, 11'd1024},
    {1'b1, 3'd0, 1'b0, 7'd2,  6'd24, 11'd768},
    {1'b1, 3'd1, 1'b0, 7'd4,  6'd24, 11'd768},
    {1'b1, 3'd2, 1'b1, 7'd8,  6'd16, 11'd768},
    {1'b1, 3'd3, 1'b1, 7'd16, 6'd16, 11'd768}
  };

  int r1[3], r2[3], hi[3];
  int peer_bad, edge_bad, act_cnt;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input int halves);
    logic [2:0] cur, prv;
    prv = '0;
    peer_bad = 0; edge_bad = 0; act_cnt = 0;
    for (int s = 0; s < 3; s++) begin r1[s] = -1; r2[s] = -1; hi[s] = 0; end
    for (int i = 0; i < halves; i++) begin
      if (i % 2 == 0) @(posedge clk); else @(negedge clk);
      #1;
      cur = {fclk, bclk, mclk};
      if (cur != 3'b000) act_cnt++;
      if (pbclk !== bclk || pfclk !== fclk) peer_bad++;
      if (i > 0) begin
        if (cur[2] != prv[2] && !(prv[1] && !cur[1])) edge_bad++;
        for (int s = 0; s < 3; s++) begin
          if (cur[s] && !prv[s]) begin
            if (r1[s] < 0) r1[s] = i;
            else if (r2[s] < 0) r2[s] = i;
          end
          if (r1[s] >= 0 && r2[s] < 0 && cur[s]) hi[s]++;
        end
      end
      prv = cur;
    end
  endtask

  task automatic setcfg(input logic b, input logic [2:0] m, input logic w);
    @(negedge clk);
    base = b; mult = m; wide = w;
  endtask

  task automatic restart();
    @(negedge clk); run = 1'b0;
    repeat (3) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic check_rates(input string rm, input int mper, input int bper, input int fper);
    chk(r2[0] - r1[0] == mper, rm, r2[0] - r1[0], mper);
    chk(hi[0] == mper / 2, rm, hi[0], mper / 2);
    chk(r2[1] - r1[1] == bper, "R4 bclk period", r2[1] - r1[1], bper);
    chk(hi[1] == bper / 2, "R4 bclk duty", hi[1], bper / 2);
    chk(r2[2] - r1[2] == fper, "R5 fclk period", r2[2] - r1[2], fper);
    chk(hi[2] == fper / 2, "R5 fclk duty", hi[2], fper / 2);
    chk(edge_bad == 0, "R6 fclk moves on bclk fall", edge_bad, 0);
    chk(peer_bad == 0, "R10 peer clocks match", peer_bad, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; base = 1'b0; mult = 3'd0; wide = 1'b0; run = 1'b0; gate = 1'b0;
    repeat (4) @(negedge clk);
    chk({mclk, bclk, fclk, pbclk, pfclk, err} == 6'b0, "R1 reset state",
        {mclk, bclk, fclk, pbclk, pfclk, err}, 0);
    rst_n = 1'b1;
    observe(20);
    chk(act_cnt == 0 && err == 1'b0, "R1 idle after reset", act_cnt, 0);

    // main table: R2/R3 master-clock rates, R4/R5 bit and frame clocks
    for (int v = 0; v < 9; v++) begin
      setcfg(VEC[v][28], VEC[v][27:25], VEC[v][24]);
      restart();
      observe(2400);
      check_rates(VEC[v][28] ? "R3 mclk base384" : "R2 mclk base512",
                  int'(VEC[v][23:17]), int'(VEC[v][16:11]), int'(VEC[v][10:0]));
    end

    // R7: gate and run control
    setcfg(1'b1, 3'd1, 1'b0);
    restart();
    repeat (10) @(negedge clk);
    gate = 1'b1;
    repeat (3) @(negedge clk);
    observe(40);
    chk(act_cnt == 0, "R7 gate stops outputs", act_cnt, 0);
    @(negedge clk); gate = 1'b0;
    repeat (3) @(negedge clk);
    observe(40);
    chk(act_cnt > 0, "R7 resume after gate", act_cnt, 1);
    @(negedge clk); run = 1'b0;
    repeat (3) @(negedge clk);
    observe(40);
    chk(act_cnt == 0, "R7 run low stops outputs", act_cnt, 0);
    setcfg(1'b0, 3'd0, 1'b0);
    restart();
    repeat (5) @(negedge clk);
    run = 1'b0;
    repeat (3) @(negedge clk);
    observe(40);
    chk(act_cnt == 0, "R7 undivided mclk stops", act_cnt, 0);

    // R8: setting changes while running are ignored until restart
    setcfg(1'b0, 3'd2, 1'b0);
    restart();
    repeat (4) @(negedge clk);
    base = 1'b1; mult = 3'd3;
    repeat (3) @(negedge clk);
    observe(2400);
    chk(r2[0] - r1[0] == 8, "R8 mclk unchanged while running", r2[0] - r1[0], 8);
    chk(r2[1] - r1[1] == 32, "R8 bclk unchanged while running", r2[1] - r1[1], 32);
    restart();
    observe(2400);
    chk(r2[0] - r1[0] == 16, "R8 new mclk after restart", r2[0] - r1[0], 16);
    chk(r2[1] - r1[1] == 24, "R8 new bclk after restart", r2[1] - r1[1], 24);

    // R9: illegal combinations
    @(negedge clk); run = 1'b0;
    setcfg(1'b0, 3'd0, 1'b1);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R9 base512 wide48 flagged", err, 1);
    run = 1'b1;
    repeat (3) @(negedge clk);
    observe(60);
    chk(act_cnt == 0, "R9 illegal keeps outputs low", act_cnt, 0);
    @(negedge clk); run = 1'b0;
    setcfg(1'b0, 3'd5, 1'b0);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R9 base512 code5 flagged", err, 1);
    setcfg(1'b1, 3'd4, 1'b0);
    repeat (3) @(negedge clk);
    chk(err == 1'b1, "R9 base384 code4 flagged", err, 1);
    setcfg(1'b1, 3'd3, 1'b0);
    repeat (3) @(negedge clk);
    chk(err == 1'b0, "R9 base384 code3 legal", err, 0);
    setcfg(1'b0, 3'd4, 1'b0);
    repeat (3) @(negedge clk);
    chk(err == 1'b0, "R9 base512 code4 legal", err, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule